// File: doc/BRIEF.md
# Double-Banked Coefficient Store with Boundary-Aligned Swap

This block holds two banks of filter coefficients. A host loads a complete new coefficient set into one bank while a filter datapath keeps reading the other bank, with no stall on either side. When the host has finished loading, it raises a commit request. The block records the request as pending and exchanges the roles of the two banks only on the next sample-period start strobe. A single accumulation pass therefore never uses coefficients from both banks.

Writes from the host always go to the bank that is currently inactive. Reads from the filter always come from the active bank, and read data arrives one cycle after the address. Two status outputs report the active bank index and whether a commit is still waiting for its boundary. Commits may follow one another back to back, which supports adaptive retraining of the impulse response. After a swap, the host writes into the bank that the filter was reading before.

Top module: `coef_pingpong`

## Requirements
- R1: After reset, bank 0 is active (`active_bank` = 0) and no commit is pending (`swap_pending` = 0).
- R2: A host write (`wr_en` = 1) stores `wr_data` at `wr_addr` in the inactive bank only. The active bank's contents, as seen on the read port, do not change.
- R3: `rd_data` holds the active bank's word at the `rd_addr` sampled one clock edge earlier. The latency is exactly one cycle.
- R4: `commit` with no strobe in the same cycle sets `swap_pending` to 1 in the next cycle. `active_bank` does not change.
- R5: On a cycle where `frame_start` = 1 and a commit is pending, `active_bank` toggles and `swap_pending` clears, both visible in the next cycle.
- R6: `active_bank` changes only on a cycle where `frame_start` = 1. A strobe with no pending commit leaves `active_bank` unchanged.
- R7: A commit made while another commit is pending merges into it. The next strobe causes one toggle, not two.
- R8: A commit in the same cycle as a strobe is served by that strobe. The bank toggles and `swap_pending` is 0 in the next cycle.
- R9: Writes made while a commit is pending still go to the inactive bank. After the swap, those words are visible on the read port, and new writes go to the bank that was previously active.
- R10: Commits repeated back to back across consecutive strobes each toggle the bank once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | ADDR_W | Host write address (inactive bank) |
| wr_data | input | DATA_W | Host write data |
| commit | input | 1 | Request to swap banks at the next boundary |
| frame_start | input | 1 | Sample-period start strobe (safe swap point) |
| rd_addr | input | ADDR_W | Filter read address (active bank) |
| rd_data | output | DATA_W | Registered read data from the active bank |
| active_bank | output | 1 | Index of the bank being read |
| swap_pending | output | 1 | A commit is waiting for the next strobe |

## Verification
The bench builds the block with DEPTH = 16 and DATA_W = 16. At that size it can fill every address of a bank and read it back across several swaps within a short run. A word that leaks into the wrong bank shows up as a mismatch on a specific address. The bench also sets USE_RESET_MEM = 1, so both banks start at zero. This makes the read-back before any write deterministic, and a write that lands in the active bank is then visible against a known background.

// File: rtl/coef_pingpong_pkg.sv
package coef_pingpong_pkg;
   typedef enum logic [1:0] {
      SW_IDLE    = 2'd0,
      SW_PENDING = 2'd1
   } swap_state_t;
endpackage

// File: rtl/coef_bank.sv
module coef_bank #(
   parameter int DEPTH         = 1024,
   parameter int DATA_W        = 24,
   parameter bit USE_RESET_MEM = 1'b0,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (USE_RESET_MEM) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];
endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl
   import coef_pingpong_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   input  logic frame_start,
   output logic active,
   output logic pending
);
   swap_state_t st;
   logic        act_q;
   logic        do_swap;

   assign do_swap = frame_start & ((st == SW_PENDING) | commit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= SW_IDLE;
         act_q <= 1'b0;
      end else begin
         if (do_swap) begin
            act_q <= ~act_q;
            st    <= SW_IDLE;
         end else if (commit) begin
            st    <= SW_PENDING;
         end
      end
   end

   assign active  = act_q;
   assign pending = (st == SW_PENDING);
endmodule

// File: rtl/coef_pingpong.sv
module coef_pingpong #(
   parameter int DEPTH         = 1024,
   parameter int DATA_W        = 24,
   parameter bit USE_RESET_MEM = 1'b0,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic              frame_start,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              active_bank,
   output logic              swap_pending
);
   initial begin
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic              act;
   logic [DATA_W-1:0] bank_q [2];
   logic [DATA_W-1:0] rd_q;

   swap_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit),
      .frame_start (frame_start),
      .active      (act),
      .pending     (swap_pending)
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      coef_bank #(
         .DEPTH         (DEPTH),
         .DATA_W        (DATA_W),
         .USE_RESET_MEM (USE_RESET_MEM)
      ) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && (act != 1'(b))),
         .waddr (wr_addr),
         .wdata (wr_data),
         .raddr (rd_addr),
         .rdata (bank_q[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= bank_q[act];
   end

   assign rd_data     = rd_q;
   assign active_bank = act;
endmodule

// File: rtl/coef_pingpong_chk.sv
module coef_pingpong_chk (
   input logic clk,
   input logic rst_n,
   input logic commit,
   input logic frame_start,
   input logic active_bank,
   input logic swap_pending
);
   a_r4_commit_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !frame_start) |=> (swap_pending && $stable(active_bank)));
   a_r5_strobe_swaps: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && swap_pending) |=> (!swap_pending && (active_bank != $past(active_bank))));
   a_r6_swap_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start) |=> $stable(active_bank));
   a_r6_idle_strobe_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !swap_pending && !commit) |=> $stable(active_bank));
   a_r8_same_cycle_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && commit) |=> (!swap_pending && (active_bank != $past(active_bank))));
endmodule

bind coef_pingpong coef_pingpong_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .commit       (commit),
   .frame_start  (frame_start),
   .active_bank  (active_bank),
   .swap_pending (swap_pending)
);

// File: tb/sim_coef_pingpong.sv
module sim_coef_pingpong;
   localparam int DEPTH  = 16;
   localparam int DATA_W = 16;
   localparam int AW     = $clog2(DEPTH);

   logic              clk = 0;
   logic              rst_n = 0;
   logic              wr_en = 0;
   logic [AW-1:0]     wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              commit = 0;
   logic              frame_start = 0;
   logic [AW-1:0]     rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              active_bank;
   logic              swap_pending;

   int checks = 0;
   int errors = 0;
   logic [DATA_W-1:0] model [2][DEPTH];
   logic exp_bank = 0;

   always #2 clk = ~clk;

   coef_pingpong #(.DEPTH(DEPTH), .DATA_W(DATA_W), .USE_RESET_MEM(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .commit(commit), .frame_start(frame_start), .rd_addr(rd_addr), .rd_data(rd_data),
      .active_bank(active_bank), .swap_pending(swap_pending));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic host_wr(input int a, input int d);
      wr_en = 1; wr_addr = AW'(a); wr_data = DATA_W'(d);
      tick();
      model[~exp_bank][a] = DATA_W'(d);
      wr_en = 0;
   endtask

   task automatic read_chk(input string req, input int a);
      rd_addr = AW'(a);
      tick();
      chk(req, rd_data, model[exp_bank][a]);
   endtask

   task automatic strobe(input logic with_commit);
      frame_start = 1; commit = with_commit;
      tick();
      frame_start = 0; commit = 0;
   endtask

   task automatic do_commit();
      commit = 1; tick(); commit = 0;
   endtask

   task automatic t_reset();
      chk("R1 bank", active_bank, 0);
      chk("R1 pending", swap_pending, 0);
      read_chk("R3 reset read", 3);
   endtask

   task automatic t_write_inactive();
      for (int i = 0; i < DEPTH; i++) host_wr(i, 16'h1000 + i);
      for (int i = 0; i < DEPTH; i += 5) read_chk("R2 active unchanged", i);
   endtask

   task automatic t_pending_and_swap();
      do_commit();
      chk("R4 pending set", swap_pending, 1);
      chk("R4 bank held", active_bank, exp_bank);
      tick(); tick();
      chk("R6 no strobe no swap", active_bank, exp_bank);
      strobe(0);
      exp_bank = ~exp_bank;
      chk("R5 toggled", active_bank, exp_bank);
      chk("R5 pending cleared", swap_pending, 0);
      for (int i = 0; i < DEPTH; i += 3) read_chk("R3 new bank data", i);
   endtask

   task automatic t_idle_strobe();
      strobe(0);
      chk("R6 idle strobe", active_bank, exp_bank);
   endtask

   task automatic t_merge_and_pending_writes();
      do_commit();
      host_wr(2, 16'hBEEF);
      do_commit();
      host_wr(7, 16'hCAFE);
      read_chk("R9 active untouched while pending", 2);
      strobe(0);
      exp_bank = ~exp_bank;
      chk("R7 single toggle", active_bank, exp_bank);
      chk("R7 pending cleared", swap_pending, 0);
      read_chk("R9 pending write visible", 2);
      read_chk("R9 pending write visible b", 7);
      host_wr(2, 16'h5555);
      read_chk("R9 new writes to old bank", 2);
   endtask

   task automatic t_same_cycle();
      strobe(1);
      exp_bank = ~exp_bank;
      chk("R8 same-cycle swap", active_bank, exp_bank);
      chk("R8 pending clear", swap_pending, 0);
      read_chk("R8 data after swap", 2);
   endtask

   task automatic t_back_to_back();
      for (int k = 0; k < 4; k++) begin
         host_wr(k, 16'hA000 + k);
         do_commit();
         strobe(0);
         exp_bank = ~exp_bank;
         chk("R10 back-to-back toggle", active_bank, exp_bank);
         read_chk("R10 fresh word", k);
      end
   endtask

   initial begin
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < DEPTH; i++) model[b][i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      t_reset();
      t_write_inactive();
      t_pending_and_swap();
      t_idle_strobe();
      t_merge_and_pending_writes();
      t_same_cycle();
      t_back_to_back();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule